// File: doc/BRIEF.md
# Speculation-safe coherence request gate

This block decides whether a miss in a small speculative filter cache may be serviced by the coherence fabric. The rule is that servicing the miss must not change the state of any non-speculative cache. Each request carries a speculative flag and a head-of-queue flag. It also carries a snoop summary with three facts: whether another private cache holds the line in E or M, whether that holder sits on the direct path to memory, and whether any other private cache holds the line at all. The gate answers one cycle later with a grant or a NACK. A grant carries the state the line takes in the filter cache. That state is only S, or SE, which marks the line as a candidate for exclusivity and looks like S to the protocol.

When an access to an SE line commits, or a store commits, the gate queues an asynchronous upgrade. This never stalls commit. Queued upgrades leave the gate one at a time. When the L1 does not already hold the line exclusively, the upgrade comes with an invalidate broadcast to every filter cache. That broadcast lasts a fixed number of cycles, so its timing reveals nothing about which filter caches hold copies.

Top module: `spec_coh_gate`

## Requirements
- R1: `rsp_state_o` is encoded as 2'b00 = I, 2'b01 = S and 2'b10 = SE. It never shows 2'b11 and shows I whenever there is no grant. The filter cache never receives E or M.
- R2: A valid request is granted one cycle after it is sampled when no other private cache holds the line in E or M, or when the E/M holder lies on the direct path to memory. `rsp_addr_o` echoes the address.
- R3: A request that is speculative and not at the head of the queue, where an off-path cache holds the line in E or M, gets a one-cycle NACK pulse and no grant. The same request marked non-speculative or at the head is granted.
- R4: A grant gives SE when no other private cache holds the line and the request is not a speculative store. Otherwise it gives S.
- R5: A commit marked SE, or a commit of a store, queues an upgrade. Upgrades are issued in commit order as one-cycle `upg_valid_o` pulses with the committed address.
- R6: When the committing core's L1 is not exclusive, `bcast_valid_o` rises together with the upgrade pulse and stays high for exactly BCAST_LEN cycles, carrying that address. No other upgrade issues while a broadcast is active.
- R7: An upgrade whose commit reported the L1 as already exclusive issues with no broadcast.
- R8: The queue holds QDEPTH (4) upgrades. A commit that arrives while the queue is full is dropped and never issued.
- R9: While `rst_ni` is low, all outputs are 0.
- R10: `bcast_ack_i` has no effect: the broadcast length does not change when filter caches acknowledge early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Miss request valid |
| req_addr_i | input | AW | Line address of the request |
| req_spec_i | input | 1 | Request is still speculative |
| req_store_i | input | 1 | Request is a store |
| req_head_i | input | 1 | Request is at the head of the instruction queue |
| snp_other_em_i | input | 1 | Another private cache holds the line in E or M |
| snp_on_path_i | input | 1 | That E/M holder lies on the direct path to memory |
| snp_other_any_i | input | 1 | Any other private cache holds the line |
| rsp_grant_o | output | 1 | Grant pulse |
| rsp_nack_o | output | 1 | NACK pulse |
| rsp_state_o | output | 2 | Granted filter-cache state |
| rsp_addr_o | output | AW | Address of the answered request |
| commit_valid_i | input | 1 | Access commits |
| commit_addr_i | input | AW | Committed line address |
| commit_se_i | input | 1 | Committed line is marked SE |
| commit_store_i | input | 1 | Committed access is a store |
| commit_l1_excl_i | input | 1 | L1 already holds the line exclusively |
| upg_valid_o | output | 1 | Upgrade request pulse to the L1 |
| upg_addr_o | output | AW | Upgrade address |
| bcast_valid_o | output | 1 | Filter-cache invalidate broadcast active |
| bcast_addr_o | output | AW | Broadcast address |
| bcast_ack_i | input | NFC | Early acknowledgements from filter caches |

## Verification
The hardest case to reach is a full upgrade queue. Upgrades drain one per cycle unless a broadcast holds the queue. The stimulus therefore first commits a line with a non-exclusive L1, which starts a long broadcast, and then sends a burst of commits so that some arrive at full occupancy. NACKs also need the rare snoop pattern of an off-path E/M holder together with a speculative, non-head request. The directed phase sweeps every snoop combination before a long random phase mixes all of these cases.

// File: rtl/spec_coh_pkg.sv
package spec_coh_pkg;
  typedef enum logic [1:0] {
    L0_I  = 2'b00,
    L0_S  = 2'b01,
    L0_SE = 2'b10
  } l0_state_e;
endpackage

// File: rtl/coh_decide.sv
module coh_decide
  import spec_coh_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_spec_i,
  input  logic          req_store_i,
  input  logic          req_head_i,
  input  logic          snp_other_em_i,
  input  logic          snp_on_path_i,
  input  logic          snp_other_any_i,
  output logic          grant_o,
  output logic          nack_o,
  output logic [1:0]    state_o,
  output logic [AW-1:0] addr_o
);
  logic      safe_now;
  logic      conflict;
  logic      do_grant;
  logic      do_nack;
  l0_state_e grant_state;

  // off-path E/M holder would be downgraded by servicing this miss
  assign conflict = snp_other_em_i && !snp_on_path_i;
  assign safe_now = !req_spec_i || req_head_i;
  assign do_nack  = req_valid_i && conflict && !safe_now;
  assign do_grant = req_valid_i && !do_nack;

  always_comb begin
    grant_state = L0_S;
    if (!snp_other_any_i && !(req_store_i && req_spec_i)) grant_state = L0_SE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o <= 1'b0;
      nack_o  <= 1'b0;
      state_o <= L0_I;
      addr_o  <= '0;
    end else begin
      grant_o <= do_grant;
      nack_o  <= do_nack;
      state_o <= do_grant ? grant_state : L0_I;
      addr_o  <= req_valid_i ? req_addr_i : addr_o;
    end
  end

  a_r1_no_code3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'b11);
  a_r1_idle_is_i: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_o |-> state_o == L0_I);
  a_r3_one_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && nack_o));
  a_r3_nack_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && snp_other_em_i && !snp_on_path_i && req_spec_i && !req_head_i)
    |=> nack_o);
  a_r2_grant_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (!snp_other_em_i || snp_on_path_i)) |=> grant_o);
endmodule

// File: rtl/upg_queue.sv
module upg_queue #(
  parameter int AW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          push_bc_i,
  input  logic          pop_i,
  output logic          empty_o,
  output logic [AW-1:0] head_addr_o,
  output logic          head_bc_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic          bc_q   [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          full;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty_o = (count == '0);
  assign do_push = push_i && !full;   // full at the edge: entry dropped
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          addr_q[g] <= '0;
          bc_q[g]   <= 1'b0;
        end else if (do_push && wr_ptr == PW'(g)) begin
          addr_q[g] <= push_addr_i;
          bc_q[g]   <= push_bc_i;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  assign head_addr_o = addr_q[rd_ptr];
  assign head_bc_o   = bc_q[rd_ptr];

  a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CW'(DEPTH));
  a_r8_full_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i) |=> count == CW'(DEPTH));
endmodule

// File: rtl/bcast_timer.sv
module bcast_timer #(
  parameter int AW        = 32,
  parameter int NFC       = 4,
  parameter int BCAST_LEN = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           need_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [NFC-1:0] ack_i,
  output logic           idle_o,
  output logic           bcast_valid_o,
  output logic [AW-1:0]  bcast_addr_o
);
  localparam int TW = $clog2(BCAST_LEN + 1);

  logic [TW-1:0] remain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain       <= '0;
      bcast_addr_o <= '0;
    end else if (start_i) begin
      remain       <= need_i ? TW'(BCAST_LEN) : '0;
      bcast_addr_o <= addr_i;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign bcast_valid_o = (remain != '0);
  assign idle_o        = (remain == '0);

  a_r10_ack_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ack_i != '0) && remain > TW'(1)) |=> bcast_valid_o);
  a_r6_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcast_valid_o && !start_i) |=> $stable(bcast_addr_o));
endmodule

// File: rtl/spec_coh_gate.sv
module spec_coh_gate
  import spec_coh_pkg::*;
#(
  parameter int AW        = 32,
  parameter int QDEPTH    = 4,
  parameter int NFC       = 4,
  parameter int BCAST_LEN = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic           req_spec_i,
  input  logic           req_store_i,
  input  logic           req_head_i,
  input  logic           snp_other_em_i,
  input  logic           snp_on_path_i,
  input  logic           snp_other_any_i,
  output logic           rsp_grant_o,
  output logic           rsp_nack_o,
  output logic [1:0]     rsp_state_o,
  output logic [AW-1:0]  rsp_addr_o,
  input  logic           commit_valid_i,
  input  logic [AW-1:0]  commit_addr_i,
  input  logic           commit_se_i,
  input  logic           commit_store_i,
  input  logic           commit_l1_excl_i,
  output logic           upg_valid_o,
  output logic [AW-1:0]  upg_addr_o,
  output logic           bcast_valid_o,
  output logic [AW-1:0]  bcast_addr_o,
  input  logic [NFC-1:0] bcast_ack_i
);
  logic          q_push, q_pop, q_empty, q_head_bc, t_idle;
  logic [AW-1:0] q_head_addr;

  coh_decide #(.AW(AW)) u_decide (
    .clk_i, .rst_ni,
    .req_valid_i, .req_addr_i, .req_spec_i, .req_store_i, .req_head_i,
    .snp_other_em_i, .snp_on_path_i, .snp_other_any_i,
    .grant_o (rsp_grant_o),
    .nack_o  (rsp_nack_o),
    .state_o (rsp_state_o),
    .addr_o  (rsp_addr_o)
  );

  assign q_push = commit_valid_i && (commit_se_i || commit_store_i);
  assign q_pop  = !q_empty && t_idle;

  upg_queue #(.AW(AW), .DEPTH(QDEPTH)) u_queue (
    .clk_i, .rst_ni,
    .push_i      (q_push),
    .push_addr_i (commit_addr_i),
    .push_bc_i   (!commit_l1_excl_i),
    .pop_i       (q_pop),
    .empty_o     (q_empty),
    .head_addr_o (q_head_addr),
    .head_bc_o   (q_head_bc)
  );

  bcast_timer #(.AW(AW), .NFC(NFC), .BCAST_LEN(BCAST_LEN)) u_timer (
    .clk_i, .rst_ni,
    .start_i       (q_pop),
    .need_i        (q_head_bc),
    .addr_i        (q_head_addr),
    .ack_i         (bcast_ack_i),
    .idle_o        (t_idle),
    .bcast_valid_o (bcast_valid_o),
    .bcast_addr_o  (bcast_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upg_valid_o <= 1'b0;
      upg_addr_o  <= '0;
    end else begin
      upg_valid_o <= q_pop;
      if (q_pop) upg_addr_o <= q_head_addr;
    end
  end

  a_r6_bcast_with_upg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bcast_valid_o) |-> upg_valid_o);
  a_r6_bcast_addr_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bcast_valid_o) |-> bcast_addr_o == upg_addr_o);
  a_r6_no_issue_in_bcast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcast_valid_o && !$rose(bcast_valid_o)) |-> !upg_valid_o);
endmodule

// File: tb/spec_coh_gate_tb.sv
module spec_coh_gate_tb;
  localparam int AW = 32, QD = 4, NFC = 4, BL = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 0, req_spec = 0, req_store = 0, req_head = 0;
  logic [AW-1:0] req_addr = 0;
  logic          s_em = 0, s_path = 0, s_any = 0;
  logic          c_valid = 0, c_se = 0, c_store = 0, c_excl = 0;
  logic [AW-1:0] c_addr = 0;
  logic [NFC-1:0] ack = 0;
  logic          grant, nack, upg, bcv;
  logic [1:0]    state;
  logic [AW-1:0] raddr, uaddr, baddr;

  spec_coh_gate #(.AW(AW), .QDEPTH(QD), .NFC(NFC), .BCAST_LEN(BL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_spec_i(req_spec),
    .req_store_i(req_store), .req_head_i(req_head),
    .snp_other_em_i(s_em), .snp_on_path_i(s_path), .snp_other_any_i(s_any),
    .rsp_grant_o(grant), .rsp_nack_o(nack), .rsp_state_o(state), .rsp_addr_o(raddr),
    .commit_valid_i(c_valid), .commit_addr_i(c_addr), .commit_se_i(c_se),
    .commit_store_i(c_store), .commit_l1_excl_i(c_excl),
    .upg_valid_o(upg), .upg_addr_o(uaddr),
    .bcast_valid_o(bcv), .bcast_addr_o(baddr), .bcast_ack_i(ack)
  );

  int checks = 0, errors = 0;
  int drops_seen = 0, nacks_seen = 0;

  // reference model
  bit          m_grant, m_nack, m_upg;
  logic [1:0]  m_state;
  logic [AW-1:0] m_raddr, m_uaddr, m_baddr;
  int          m_bc;
  logic [AW-1:0] q_addr[$];
  bit          q_bc[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_grant = 0; m_nack = 0; m_upg = 0; m_state = 0; m_raddr = 0;
      m_uaddr = 0; m_baddr = 0; m_bc = 0; q_addr.delete(); q_bc.delete();
    end else begin
      int pre;
      m_grant = 0; m_nack = 0; m_state = 2'b00;
      if (req_valid) begin
        m_raddr = req_addr;
        if (s_em && !s_path && req_spec && !req_head) begin
          m_nack = 1; nacks_seen++;
        end else begin
          m_grant = 1;
          m_state = (!s_any && !(req_store && req_spec)) ? 2'b10 : 2'b01;
        end
      end
      pre = q_addr.size();
      m_upg = 0;
      if (m_bc > 0) m_bc--;
      else if (pre > 0) begin
        m_upg = 1;
        m_uaddr = q_addr.pop_front();
        m_baddr = m_uaddr;
        m_bc = q_bc.pop_front() ? BL : 0;
      end
      if (c_valid && (c_se || c_store)) begin
        if (pre < QD) begin q_addr.push_back(c_addr); q_bc.push_back(!c_excl); end
        else drops_seen++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(grant == m_grant, "R2", "grant", grant, m_grant);
    chk(nack == m_nack, "R3", "nack", nack, m_nack);
    chk(state == m_state, "R1/R4", "state", state, m_state);
    if (m_grant || m_nack) chk(raddr == m_raddr, "R2", "rsp_addr", raddr, m_raddr);
    chk(upg == m_upg, "R5", "upg_valid", upg, m_upg);
    if (m_upg) chk(uaddr == m_uaddr, "R5", "upg_addr", uaddr, m_uaddr);
    chk(bcv == (m_bc > 0), "R6/R7/R10", "bcast_valid", bcv, m_bc > 0);
    if (m_bc > 0) chk(baddr == m_baddr, "R6", "bcast_addr", baddr, m_baddr);
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_spec = 0; req_store = 0; req_head = 0;
    s_em = 0; s_path = 0; s_any = 0;
    c_valid = 0; c_se = 0; c_store = 0; c_excl = 0; ack = 0;
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  bit done = 0;

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs zero during reset
    chk({grant, nack, state, upg, bcv} == 0, "R9", "reset outputs",
        {grant, nack, state, upg, bcv}, 0);
    rst_n = 1;
    step();
    // directed sweep of snoop/request combinations (R2 R3 R4)
    for (int i = 0; i < 64; i++) begin
      req_valid = 1; req_addr = 32'h1000 + i;
      {req_spec, req_head, req_store, s_em, s_path, s_any} = 6'(i);
      step();
    end
    idle_inputs();
    step();
    // R6 + R8: broadcast blocks the queue, burst overflows it
    c_valid = 1; c_se = 1; c_excl = 0; c_addr = 32'hA0;
    step();
    for (int i = 0; i < 6; i++) begin
      c_valid = 1; c_se = (i % 2 == 0); c_store = !c_se; c_excl = (i % 3 == 0);
      c_addr = 32'hB0 + i; ack = 4'hF;   // R10 early acks
      step();
    end
    idle_inputs();
    repeat (40) step();
    // R7: exclusive L1, back-to-back upgrades without broadcast
    for (int i = 0; i < 3; i++) begin
      c_valid = 1; c_store = 1; c_excl = 1; c_addr = 32'hC0 + i;
      step();
    end
    idle_inputs();
    repeat (10) step();
    // random mix
    for (int i = 0; i < 4000; i++) begin
      req_valid = $urandom_range(0, 1); req_addr = $urandom;
      req_spec = $urandom_range(0, 1); req_store = $urandom_range(0, 1);
      req_head = ($urandom_range(0, 3) == 0);
      s_em = $urandom_range(0, 1); s_path = $urandom_range(0, 1);
      s_any = s_em | $urandom_range(0, 1);
      c_valid = ($urandom_range(0, 2) == 0); c_addr = $urandom;
      c_se = $urandom_range(0, 1); c_store = $urandom_range(0, 1);
      c_excl = $urandom_range(0, 1); ack = 4'($urandom);
      step();
    end
    idle_inputs();
    repeat (60) step();
    chk(drops_seen > 0, "R8", "overflow reached", drops_seen, 1);
    chk(nacks_seen > 0, "R3", "nack reached", nacks_seen, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule